// File: doc/BRIEF.md
# Serial Channel Interrupt Aggregator

This block collects interrupt causes from up to 32 serial channels, arranged as up to four groups of eight, and turns them into one host interrupt line. Each channel shows a cause byte; some cause flags follow live FIFO conditions and others are latched events that clear when the host reads the byte. A per-channel enable register decides which causes raise a service request. Requests are summarised twice: a per-group register with one bit per channel, and a top status register with one bit per group. The host can therefore find the interrupting channel in three reads.

A periodic tick timer with a 3-bit rate code can raise the host line on its own. A periodic-only mode lets the host run purely on ticks while the channel causes stay readable. A global enable gates the host line. Writing the strobe bit ends the interrupt: the line drops, and it is raised again one clock later if a source is still pending.

The host line comes from a three-state machine. In `ST_ARMED` the line is low while the machine waits for a source. In `ST_FIRE` the line is high. `ST_RELEASE` is the one-cycle low gap after an end-of-interrupt. The transitions are:
- `ARMED->FIRE` when the global enable is set and a source is pending.
- `FIRE->RELEASE` on a strobe.
- `FIRE->ARMED` when the global enable is cleared.
- `RELEASE->FIRE` when the enable is set and a source is still pending.
- `RELEASE->ARMED` otherwise.

Top module: `irqagg_top`

## Requirements
- R1: The cause byte of channel c is read at address c (0x00-0x1F, group = bits 4:3). Bit 5 (0x20) follows the channel's Rx-trigger input and bit 4 (0x10) follows its Tx-empty input, both live. Bits 7:6 read zero.
- R2: Bit 3 (0x08) of the cause byte latches a special-receive pulse and clears when that cause byte is read. A new pulse in the same cycle as the read wins, so the bit stays set.
- R3: Bits 2, 1 and 0 (0x04 CD, 0x02 CTS, 0x01 DSR) latch either edge of the synchronised modem inputs and clear when the cause byte is read.
- R4: The enable register of channel c (address 0x20+c) holds bit 0x01 (modem causes), 0x02 (Rx trigger), 0x04 (special receive) and 0x10 (Tx empty); other bits read zero. A cause is recorded in the cause byte whatever its enable, and the channel requests service when any enabled cause is set.
- R5: The group summary at 0x40+g has bit n set while channel n of group g requests service.
- R6: The top status at 0x44 has bit g set while group g is enabled and any of its channels requests service. Bits 7:4 always read zero.
- R7: The tick/group control register at 0x45 holds group enables in bits 3:0 (0x01 is group 0 through 0x08 for group 3). For a disabled group, cause, enable and summary reads return zero, reads do not clear latched causes, writes are ignored, and the group is absent from the top status.
- R8: The host control register at 0x46 has global enable bit 0x08. The host line is never high in the cycle after the enable was seen clear.
- R9: With the enable set, the host line rises on the clock after a source becomes pending. It stays high until a write to 0x46 with strobe bit 0x04. It is then low for one cycle and rises on the next clock if a source is still pending.
- R10: Bits 6:4 of 0x45 select the tick rate. Codes 0 and 7 stop the timer. Code k in 1..6 gives a period of TICK_BASE << (6-k) cycles. Each tick latches a pending flag that only a strobe clears. After the code is written from zero, the line rises TICK_BASE << (6-k) plus 1 cycles after the write edge.
- R11: Bit 7 of 0x45 (periodic-only) keeps channel requests from raising the host line; ticks still raise it.
- R12: Read data appears on the cycle after the read strobe and is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 7 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears latched causes of a cause byte) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_trig_i | input | NUM_GROUPS*8 | Per-channel Rx FIFO trigger level reached |
| tx_empty_i | input | NUM_GROUPS*8 | Per-channel Tx FIFO empty |
| rx_special_i | input | NUM_GROUPS*8 | Per-channel special receive condition pulse |
| cd_i | input | NUM_GROUPS*8 | Per-channel carrier detect, asynchronous |
| cts_i | input | NUM_GROUPS*8 | Per-channel clear-to-send, asynchronous |
| dsr_i | input | NUM_GROUPS*8 | Per-channel data-set-ready, asynchronous |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The end-of-interrupt strobe and a still-active channel request can land in the same cycle. The bench provokes this by holding an enabled Rx-trigger cause high while it writes the strobe. It then judges the line cycle by cycle: the line must be low on the sample right after the write edge and high again one clock later, which shows that the release state neither swallows nor delays the pending request. The same-cycle clash between a clear-on-read and a new special-receive pulse is also driven, and the latched bit must survive it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int CH_PER_GROUP = 8;
    localparam int MAX_GROUPS   = 4;
    localparam int MAX_CH       = CH_PER_GROUP * MAX_GROUPS;
    localparam int ADDR_W       = 7;

    // register addresses
    localparam logic [ADDR_W-1:0] A_GSUM_BASE = 7'h40;
    localparam logic [ADDR_W-1:0] A_TOP_STAT  = 7'h44;
    localparam logic [ADDR_W-1:0] A_TICK_CTL  = 7'h45;
    localparam logic [ADDR_W-1:0] A_HOST_CTL  = 7'h46;

    // host control bits
    localparam int HC_ENABLE = 3;
    localparam int HC_STROBE = 2;

    // channel enable bits
    localparam int EN_MODEM   = 0;
    localparam int EN_RXTRIG  = 1;
    localparam int EN_SPECIAL = 2;
    localparam int EN_TXEMPTY = 4;
    localparam logic [7:0] EN_MASK = 8'h17;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_FIRE    = 2'd1,
        ST_RELEASE = 2'd2
    } host_state_e;

endpackage

// File: rtl/irqagg_chan.sv
module irqagg_chan
    import irqagg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_trig_i,
    input  logic       tx_empty_i,
    input  logic       rx_special_i,
    input  logic       cd_i,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       rd_clr_i,
    input  logic       en_we_i,
    input  logic [7:0] en_wdata_i,
    output logic [7:0] cause_o,
    output logic [7:0] en_o,
    output logic       req_o
);

    logic [2:0] mdm_s1, mdm_s2, mdm_prev, mdm_delta, mdm_q;
    logic       spc_q;
    logic [7:0] en_q;
    logic [7:0] gate;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdm_s1   <= '0;
            mdm_s2   <= '0;
            mdm_prev <= '0;
        end else begin
            mdm_s1   <= {cd_i, cts_i, dsr_i};
            mdm_s2   <= mdm_s1;
            mdm_prev <= mdm_s2;
        end
    end

    assign mdm_delta = mdm_s2 ^ mdm_prev;

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdm_q <= '0;
            spc_q <= 1'b0;
        end else begin
            mdm_q <= mdm_delta | (mdm_q & ~{3{rd_clr_i}});
            spc_q <= rx_special_i | (spc_q & ~rd_clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we_i)
            en_q <= en_wdata_i & EN_MASK;
    end

    assign cause_o = {2'b00, rx_trig_i, tx_empty_i, spc_q, mdm_q};
    assign en_o    = en_q;

    assign gate = {2'b00, en_q[EN_RXTRIG], en_q[EN_TXEMPTY], en_q[EN_SPECIAL],
                   {3{en_q[EN_MODEM]}}};
    assign req_o = |(cause_o & gate);

endmodule

// File: rtl/irqagg_tick.sv
module irqagg_tick #(
    parameter int TICK_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate_i,
    input  logic       clr_i,
    output logic       pend_o
);

    localparam int MAX_PERIOD = TICK_BASE << 5;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             running;
    logic             fire;
    logic             pend_q;

    assign running  = (rate_i != 3'd0) && (rate_i != 3'd7);
    assign last_cnt = running ? CNT_W'((TICK_BASE << (6 - int'(rate_i))) - 1) : '0;
    assign fire     = running && (cnt_q >= last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!running || fire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= fire | (pend_q & ~clr_i);
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irqagg_hostfsm.sv
module irqagg_hostfsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic src_i,
    input  logic strobe_i,
    output logic irq_o
);

    host_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_ARMED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (en_i && src_i) state_d = ST_FIRE;
            ST_FIRE: begin
                if (!en_i)         state_d = ST_ARMED;
                else if (strobe_i) state_d = ST_RELEASE;
            end
            ST_RELEASE: state_d = (en_i && src_i) ? ST_FIRE : ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int TICK_BASE  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [6:0]                     reg_addr,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [7:0]                     reg_wdata,
    output logic [7:0]                     reg_rdata,
    input  logic [NUM_GROUPS*8-1:0]        rx_trig_i,
    input  logic [NUM_GROUPS*8-1:0]        tx_empty_i,
    input  logic [NUM_GROUPS*8-1:0]        rx_special_i,
    input  logic [NUM_GROUPS*8-1:0]        cd_i,
    input  logic [NUM_GROUPS*8-1:0]        cts_i,
    input  logic [NUM_GROUPS*8-1:0]        dsr_i,
    output logic                           host_irq_o
);

    localparam int NCH = NUM_GROUPS * CH_PER_GROUP;

    logic [7:0]        tctl_q;
    logic              hen_q;
    logic [7:0]        cause_arr [MAX_CH];
    logic [7:0]        en_arr    [MAX_CH];
    logic [MAX_CH-1:0] req_v;
    logic [7:0]        gsum      [MAX_GROUPS];
    logic [3:0]        grp_has;
    logic [3:0]        top_st;
    logic [3:0]        grp_en;
    logic              is_cause, is_en, is_gsum;
    logic [4:0]        ch_idx;
    logic              grp_ok, gsum_ok;
    logic              strobe;
    logic              tick_pend;
    logic              src_any;
    logic [7:0]        rd_val;

    assign grp_en   = tctl_q[3:0];
    assign is_cause = (reg_addr[6:5] == 2'b00);
    assign is_en    = (reg_addr[6:5] == 2'b01);
    assign is_gsum  = (reg_addr[6:2] == A_GSUM_BASE[6:2]);
    assign ch_idx   = reg_addr[4:0];
    assign grp_ok   = (int'(reg_addr[4:3]) < NUM_GROUPS) && grp_en[reg_addr[4:3]];
    assign gsum_ok  = (int'(reg_addr[1:0]) < NUM_GROUPS) && grp_en[reg_addr[1:0]];
    assign strobe   = reg_wr && (reg_addr == A_HOST_CTL) && reg_wdata[HC_STROBE];

    for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
        if (c < NCH) begin : g_real
            logic rd_clr, en_we;
            assign rd_clr = reg_rd && is_cause && grp_ok && (ch_idx == 5'(c));
            assign en_we  = reg_wr && is_en && grp_ok && (ch_idx == 5'(c));
            irqagg_chan u_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .rx_trig_i    (rx_trig_i[c]),
                .tx_empty_i   (tx_empty_i[c]),
                .rx_special_i (rx_special_i[c]),
                .cd_i         (cd_i[c]),
                .cts_i        (cts_i[c]),
                .dsr_i        (dsr_i[c]),
                .rd_clr_i     (rd_clr),
                .en_we_i      (en_we),
                .en_wdata_i   (reg_wdata),
                .cause_o      (cause_arr[c]),
                .en_o         (en_arr[c]),
                .req_o        (req_v[c])
            );
        end else begin : g_absent
            assign cause_arr[c] = '0;
            assign en_arr[c]    = '0;
            assign req_v[c]     = 1'b0;
        end
    end

    for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_grp
        assign gsum[g]    = req_v[g*CH_PER_GROUP +: CH_PER_GROUP];
        assign grp_has[g] = |gsum[g];
    end

    assign top_st  = grp_en & grp_has;
    assign src_any = tick_pend | (~tctl_q[7] & (|top_st));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tctl_q <= '0;
            hen_q  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_TICK_CTL) tctl_q <= reg_wdata;
            if (reg_addr == A_HOST_CTL) hen_q  <= reg_wdata[HC_ENABLE];
        end
    end

    always_comb begin
        rd_val = '0;
        if (is_cause) begin
            if (grp_ok) rd_val = cause_arr[ch_idx];
        end else if (is_en) begin
            if (grp_ok) rd_val = en_arr[ch_idx];
        end else if (is_gsum) begin
            if (gsum_ok) rd_val = gsum[reg_addr[1:0]];
        end else if (reg_addr == A_TOP_STAT) begin
            rd_val = {4'b0000, top_st};
        end else if (reg_addr == A_TICK_CTL) begin
            rd_val = tctl_q;
        end else if (reg_addr == A_HOST_CTL) begin
            rd_val = {4'b0000, hen_q, 3'b000};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata <= '0;
        else
            reg_rdata <= reg_rd ? rd_val : 8'h00;
    end

    irqagg_tick #(.TICK_BASE(TICK_BASE)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (tctl_q[6:4]),
        .clr_i  (strobe),
        .pend_o (tick_pend)
    );

    irqagg_hostfsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (hen_q),
        .src_i    (src_any),
        .strobe_i (strobe),
        .irq_o    (host_irq_o)
    );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       host_irq,
    input logic       glob_en,
    input logic       src_any,
    input logic       tick_pend,
    input logic       per_only
);

    p_disable_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !host_irq);

    p_rise_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> ($past(src_any) && $past(glob_en)));

    p_strobe_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && reg_wr && reg_addr == A_HOST_CTL && reg_wdata[HC_STROBE]) |=> !host_irq);

    p_hold_until_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && glob_en && !(reg_wr && reg_addr == A_HOST_CTL)) |=> host_irq);

    p_ticks_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_irq) && $past(per_only)) |-> $past(tick_pend));

    p_top_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == A_TOP_STAT) |-> (reg_rdata[7:4] == 4'h0));

    p_idle_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> (reg_rdata == 8'h00));

endmodule

bind irqagg_top irqagg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .host_irq  (host_irq_o),
    .glob_en   (hen_q),
    .src_any   (src_any),
    .tick_pend (tick_pend),
    .per_only  (tctl_q[7])
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 4;
    localparam int NCH        = NG * 8;
    localparam int TB_BASE    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [6:0]     reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic           reg_rd = 1'b0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] rx_trig = '0, tx_empty = '0, rx_special = '0;
    logic [NCH-1:0] cd = '0, cts = '0, dsr = '0;
    logic           host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top #(.NUM_GROUPS(NG), .TICK_BASE(TB_BASE)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_trig_i    (rx_trig),
        .tx_empty_i   (tx_empty),
        .rx_special_i (rx_special),
        .cd_i         (cd),
        .cts_i        (cts),
        .dsr_i        (dsr),
        .host_irq_o   (host_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R8 irq low after reset", int'(host_irq), 0);
        do_rd(7'h45, d); check("R7 control reset", d, 8'h00);
        do_rd(7'h44, d); check("R6 top status reset", d, 8'h00);
        @(negedge clk);
        check("R12 rdata idle", reg_rdata, 8'h00);
        do_wr(7'h45, 8'h0F);
    endtask

    task automatic t_layout;
        logic [7:0] d;
        @(negedge clk); rx_trig[9] = 1'b1; tx_empty[9] = 1'b1;
        do_rd(7'h09, d); check("R1 live rx+tx flags", d, 8'h30);
        @(negedge clk); rx_trig[9] = 1'b0;
        do_rd(7'h09, d); check("R1 tx only", d, 8'h10);
        @(negedge clk); tx_empty[9] = 1'b0;
        do_rd(7'h09, d); check("R1 flags follow inputs", d, 8'h00);
    endtask

    task automatic t_special;
        logic [7:0] d;
        @(negedge clk); rx_special[3] = 1'b1;
        @(negedge clk); rx_special[3] = 1'b0;
        repeat (2) @(negedge clk);
        do_rd(7'h03, d); check("R2 special latched", d, 8'h08);
        do_rd(7'h03, d); check("R2 cleared by read", d, 8'h00);
        @(negedge clk); rx_special[3] = 1'b1;
        @(negedge clk); rx_special[3] = 1'b0;
        @(negedge clk); reg_addr = 7'h03; reg_rd = 1'b1; rx_special[3] = 1'b1;
        @(negedge clk); reg_rd = 1'b0; rx_special[3] = 1'b0; d = reg_rdata;
        check("R2 read during new pulse", d, 8'h08);
        do_rd(7'h03, d); check("R2 new pulse wins over clear", d, 8'h08);
        do_rd(7'h03, d); check("R2 clear afterwards", d, 8'h00);
    endtask

    task automatic t_modem;
        logic [7:0] d;
        @(negedge clk); cd[17] = 1'b1;
        repeat (5) @(negedge clk);
        do_rd(7'h11, d); check("R3 cd rise", d, 8'h04);
        do_rd(7'h11, d); check("R3 clear on read", d, 8'h00);
        @(negedge clk); cts[17] = 1'b1;
        repeat (5) @(negedge clk);
        do_rd(7'h11, d); check("R3 cts rise", d, 8'h02);
        @(negedge clk); dsr[17] = 1'b1;
        repeat (5) @(negedge clk);
        do_rd(7'h11, d); check("R3 dsr rise", d, 8'h01);
        @(negedge clk); cd[17] = 1'b0; cts[17] = 1'b0; dsr[17] = 1'b0;
        repeat (5) @(negedge clk);
        do_rd(7'h11, d); check("R3 falling edges", d, 8'h07);
        do_rd(7'h11, d); check("R3 cleared", d, 8'h00);
    endtask

    task automatic t_enable;
        logic [7:0] d;
        @(negedge clk); rx_trig[26] = 1'b1;
        do_rd(7'h1A, d); check("R4 recorded while disabled", d, 8'h20);
        do_rd(7'h43, d); check("R5 no request without enable", d, 8'h00);
        do_rd(7'h44, d); check("R6 top idle", d, 8'h00);
        do_wr(7'h3A, 8'hFF);
        do_rd(7'h3A, d); check("R4 enable readback mask", d, 8'h17);
        do_wr(7'h3A, 8'h02);
        do_rd(7'h43, d); check("R5 summary bit 2", d, 8'h04);
        do_rd(7'h44, d); check("R6 top bit 3", d, 8'h08);
        do_wr(7'h3A, 8'h01);
        do_rd(7'h43, d); check("R4 modem enable ignores rx trig", d, 8'h00);
        @(negedge clk); rx_trig[26] = 1'b0; tx_empty[26] = 1'b1;
        do_wr(7'h3A, 8'h10);
        do_rd(7'h43, d); check("R4 tx empty enable", d, 8'h04);
        @(negedge clk); tx_empty[26] = 1'b0;
        do_wr(7'h3A, 8'h00);
    endtask

    task automatic t_group;
        logic [7:0] d;
        do_wr(7'h3A, 8'h02);
        @(negedge clk); rx_trig[26] = 1'b1;
        do_wr(7'h45, 8'h07);
        do_rd(7'h44, d); check("R7 disabled group absent from top", d, 8'h00);
        do_rd(7'h1A, d); check("R7 disabled cause reads zero", d, 8'h00);
        do_rd(7'h43, d); check("R7 disabled summary reads zero", d, 8'h00);
        do_wr(7'h3A, 8'h00);
        @(negedge clk); rx_special[24] = 1'b1;
        @(negedge clk); rx_special[24] = 1'b0;
        do_rd(7'h18, d);
        do_wr(7'h45, 8'h0F);
        do_rd(7'h3A, d); check("R7 write ignored while disabled", d, 8'h02);
        do_rd(7'h18, d); check("R7 read did not clear", d, 8'h08);
        do_rd(7'h18, d);
        @(negedge clk); rx_trig[26] = 1'b0;
        do_wr(7'h3A, 8'h00);
    endtask

    task automatic t_host;
        do_wr(7'h02 + 7'h20, 8'h02);
        do_wr(7'h46, 8'h08);
        check("R9 idle line", int'(host_irq), 0);
        @(negedge clk); rx_trig[2] = 1'b1;
        @(negedge clk); check("R9 rise next clock", int'(host_irq), 1);
        @(negedge clk); rx_trig[2] = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 held until strobe", int'(host_irq), 1);
        do_wr(7'h46, 8'h0C); check("R9 strobe drops line", int'(host_irq), 0);
        repeat (2) @(negedge clk);
        check("R9 stays low without source", int'(host_irq), 0);
        @(negedge clk); rx_trig[2] = 1'b1;
        @(negedge clk); check("R9 fire again", int'(host_irq), 1);
        do_wr(7'h46, 8'h0C); check("R9 low gap after strobe", int'(host_irq), 0);
        @(negedge clk); check("R9 re-asserts with pending source", int'(host_irq), 1);
        do_wr(7'h46, 8'h00);
        @(negedge clk); check("R8 line drops after disable", int'(host_irq), 0);
        repeat (2) @(negedge clk);
        check("R8 stays low while disabled", int'(host_irq), 0);
        @(negedge clk); rx_trig[2] = 1'b0;
        do_wr(7'h22, 8'h00);
    endtask

    task automatic t_tick;
        int n;
        do_wr(7'h45, 8'h8F);
        do_wr(7'h46, 8'h0C);
        do_wr(7'h45, 8'hEF);
        n = 0;
        while (!host_irq && n < 2000) begin @(negedge clk); n++; end
        check("R10 rate 6 delay", n, TB_BASE + 1);
        do_wr(7'h45, 8'h8F);
        do_wr(7'h46, 8'h0C);
        @(negedge clk); check("R10 pending cleared by strobe", int'(host_irq), 0);
        do_wr(7'h45, 8'hDF);
        n = 0;
        while (!host_irq && n < 2000) begin @(negedge clk); n++; end
        check("R10 rate 5 delay", n, 2 * TB_BASE + 1);
        do_wr(7'h45, 8'h8F);
        do_wr(7'h46, 8'h0C);
        repeat (4 * TB_BASE) @(negedge clk);
        check("R10 rate 0 stops ticks", int'(host_irq), 0);
    endtask

    task automatic t_per_only;
        do_wr(7'h25, 8'h02);
        @(negedge clk); rx_trig[5] = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 channel cause blocked", int'(host_irq), 0);
        do_wr(7'h45, 8'h0F);
        @(negedge clk); check("R11 cause passes when mode off", int'(host_irq), 1);
        @(negedge clk); rx_trig[5] = 1'b0;
        do_wr(7'h46, 8'h0C);
        do_wr(7'h25, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_special();
        t_modem();
        t_enable();
        t_group();
        t_host();
        t_tick();
        t_per_only();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule